// File: doc/BRIEF.md
# Iterative Booth Multiplier With Early Termination

This block multiplies two integer operands over several clock cycles, retiring a fixed group of multiplier bits per cycle through radix-4 Booth recoding. Each radix-4 digit takes one of the values 0, ±1 or ±2 and is applied to the multiplicand. The base configuration retires two bits per cycle. A parameter widens the step to several radix-4 digits per cycle, for example eight bits, which makes a faster variant. Operands may be treated as signed two's-complement or unsigned. An optional accumulate input turns the operation into a multiply-accumulate.

Latency varies with the data. Before each step the controller looks at the multiplier bits not yet consumed, together with the last recoding bit. When all of those bits are zero, or all are one for a signed operation, no later digit can change the sum, and the operation ends. The block reports how many iteration steps it used.

The controller has three states: `S_IDLE` (waiting, `ready` high), `S_RUN` (iterating) and `S_DONE` (one cycle with `done` high). The transitions are:
- IDLE→RUN when `start` is seen.
- RUN→RUN while bits remain to be consumed.
- RUN→DONE when the remaining bits are exhausted, either before a step or by the step itself.
- DONE→IDLE unconditionally.

Top module: `booth_mul`

## Requirements
- R1: After reset `ready` is 1, `done` is 0 and `result` is 0.
- R2: With `is_signed`=1 and `acc_en`=0, `result` is the exact two's-complement product of `op_a` and `op_b`, 2·W bits wide.
- R3: With `is_signed`=0 and `acc_en`=0, `result` is the exact unsigned product of `op_a` and `op_b`.
- R4: With `acc_en`=1, `result` is `acc_in` plus the product, modulo 2^(2·W). With `acc_en`=0, `acc_in` has no effect.
- R5: `iter_count` is N. N is the smallest n ≥ 0 for which the value {op_b, 1'b0}, shifted right by n·BPC bits, is all zeros, or all ones for a signed operation. The shift is arithmetic for signed and logical for unsigned. N is at most W/BPC for signed operands and at most W/BPC+1 for unsigned operands.
- R6: `done` rises max(N,1) clock edges after the edge that accepts `start`, and `ready` is 0 from the accepting edge until `done` falls.
- R7: `done` is high for exactly one cycle, and `ready` is low while `done` is high.
- R8: `start`, operand, mode and accumulate inputs that change while the block is busy do not affect the result of the operation in progress.
- R9: `result` changes only in the cycle in which `done` is high, and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted only when `ready` is high |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier, consumed BPC bits per cycle |
| is_signed | input | 1 | 1: two's-complement operands; 0: unsigned operands |
| acc_en | input | 1 | 1: add `acc_in` to the product |
| acc_in | input | 2·W | Accumulate addend |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2·W | Product or product plus addend |
| iter_count | output | $clog2(ceil(W/BPC)+2) | Iteration steps used by the last operation |

## Verification
The bench sweeps every multiplier value of an 8-bit, radix-4 instance against a set of edge multiplicands in both signed and unsigned modes. It also runs a 32-bit, eight-bit-per-cycle instance through directed extremes. The riskiest cases are these:
- Unsigned multipliers with the top bit set. A design that terminated on all-ones here, or that sign-filled the shift, would drop the final +1 digit and return a wrong product in one step too few.
- Signed multipliers of -1 and other short negatives. A design that ignored the all-ones exit would run full length and miss the expected latency.
- The most negative multiplicand times -2. Here the ±2 digits must not lose their top bit.
- Start pulses injected mid-operation, with altered operands. A controller that accepted these would corrupt the result.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } mul_state_e;
endpackage

// File: rtl/booth_digit.sv
// One radix-4 Booth digit: maps a 3-bit overlapping group to 0, +-1 or +-2 times the operand.
module booth_digit #(
    parameter int PW = 64
) (
    input  logic [2:0]    grp,
    input  logic [PW-1:0] mcand,
    output logic [PW-1:0] pp
);
    logic [PW-1:0] dbl;
    assign dbl = mcand << 1;

    always_comb begin
        unique case (grp)
            3'b001, 3'b010: pp = mcand;
            3'b011:         pp = dbl;
            3'b100:         pp = -dbl;
            3'b101, 3'b110: pp = -mcand;
            default:        pp = '0;
        endcase
    end
endmodule

// File: rtl/booth_stage.sv
// Adds DIGITS consecutive radix-4 partial products to the running sum in one cycle.
module booth_stage #(
    parameter int PW     = 64,
    parameter int DIGITS = 1
) (
    input  logic [2*DIGITS:0] q_lo,
    input  logic [PW-1:0]     mcand,
    input  logic [PW-1:0]     sum_in,
    output logic [PW-1:0]     sum_out
);
    logic [PW-1:0] part [DIGITS+1];
    assign part[0] = sum_in;

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        logic [PW-1:0] pp_k;
        logic [PW-1:0] mc_k;
        assign mc_k = mcand << (2 * k);
        booth_digit #(.PW(PW)) u_dig (
            .grp   (q_lo[2*k+2:2*k]),
            .mcand (mc_k),
            .pp    (pp_k)
        );
        assign part[k+1] = part[k] + pp_k;
    end

    assign sum_out = part[DIGITS];
endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
    parameter int W   = 32,
    parameter int BPC = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [W-1:0]                           op_a,
    input  logic [W-1:0]                           op_b,
    input  logic                                   is_signed,
    input  logic                                   acc_en,
    input  logic [2*W-1:0]                         acc_in,
    output logic                                   ready,
    output logic                                   done,
    output logic [2*W-1:0]                         result,
    output logic [$clog2((W+BPC-1)/BPC+2)-1:0]     iter_count
);
    import booth_pkg::*;

    localparam int PW     = 2 * W;
    localparam int DIGITS = BPC / 2;
    localparam int QW     = W + 1;
    localparam int MAXI   = (W + BPC - 1) / BPC + 1;
    localparam int CW     = $clog2(MAXI + 1);

    mul_state_e state_q, state_nx;

    logic [PW-1:0] mcand_q;
    logic [QW-1:0] q_q, q_nx;
    logic          sgn_q;
    logic [PW-1:0] acc_q, acc_nx;
    logic [PW-1:0] res_q;
    logic [CW-1:0] cnt_q, iters_q;
    logic          term_now, term_nx, step_en, accept, finish;

    // Remaining bits exhausted: all zero, or all one for signed operands
    assign term_now = (q_q == '0) || (sgn_q && (&q_q));
    assign q_nx     = sgn_q ? QW'($signed(q_q) >>> BPC) : (q_q >> BPC);
    assign term_nx  = (q_nx == '0) || (sgn_q && (&q_nx));

    booth_stage #(.PW(PW), .DIGITS(DIGITS)) u_stage (
        .q_lo    (q_q[2*DIGITS:0]),
        .mcand   (mcand_q),
        .sum_in  (acc_q),
        .sum_out (acc_nx)
    );

    assign accept  = (state_q == S_IDLE) && start;
    assign step_en = (state_q == S_RUN) && !term_now;
    assign finish  = (state_q == S_RUN) && (state_nx == S_DONE);

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_nx = S_RUN;
            S_RUN:   if (term_now || term_nx) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // Operand, sum and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            q_q     <= '0;
            sgn_q   <= 1'b0;
            acc_q   <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            mcand_q <= is_signed ? {{W{op_a[W-1]}}, op_a} : {{W{1'b0}}, op_a};
            q_q     <= {op_b, 1'b0};
            sgn_q   <= is_signed;
            acc_q   <= acc_en ? acc_in : '0;
            cnt_q   <= '0;
        end else if (step_en) begin
            mcand_q <= mcand_q << BPC;
            q_q     <= q_nx;
            acc_q   <= acc_nx;
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    // Result capture on completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            iters_q <= '0;
        end else if (finish) begin
            res_q   <= step_en ? acc_nx : acc_q;
            iters_q <= step_en ? cnt_q + CW'(1) : cnt_q;
        end
    end

    // Outputs
    always_comb begin
        ready      = (state_q == S_IDLE);
        done       = (state_q == S_DONE);
        result     = res_q;
        iter_count = iters_q;
    end
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int W   = 32,
    parameter int BPC = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               start,
    input logic                               ready,
    input logic                               done,
    input logic [2*W-1:0]                     result,
    input logic [$clog2((W+BPC-1)/BPC+2)-1:0] iter_count
);
    localparam int MAXI = (W + BPC - 1) / BPC + 1;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(iter_count) <= MAXI));
endmodule

bind booth_mul booth_mul_chk #(.W(W), .BPC(BPC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready      (ready),
    .done       (done),
    .result     (result),
    .iter_count (iter_count)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
    localparam int SW = 8,  SB = 2;
    localparam int FW = 32, FB = 8;
    localparam int SCW = $clog2((SW+SB-1)/SB+2);
    localparam int FCW = $clog2((FW+FB-1)/FB+2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_run = 0, n_fail = 0;

    // small radix-4 instance
    logic s_start = 0, s_sgn = 0, s_acc_en = 0;
    logic [SW-1:0] s_a = '0, s_b = '0;
    logic [2*SW-1:0] s_acc = '0, s_res;
    logic s_ready, s_done;
    logic [SCW-1:0] s_it;

    booth_mul #(.W(SW), .BPC(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op_a(s_a), .op_b(s_b),
        .is_signed(s_sgn), .acc_en(s_acc_en), .acc_in(s_acc),
        .ready(s_ready), .done(s_done), .result(s_res), .iter_count(s_it));

    // 32-bit, eight bits per cycle instance
    logic f_start = 0, f_sgn = 0, f_acc_en = 0;
    logic [FW-1:0] f_a = '0, f_b = '0;
    logic [2*FW-1:0] f_acc = '0, f_res;
    logic f_ready, f_done;
    logic [FCW-1:0] f_it;

    booth_mul #(.W(FW), .BPC(FB)) u_fast (
        .clk(clk), .rst_n(rst_n), .start(f_start), .op_a(f_a), .op_b(f_b),
        .is_signed(f_sgn), .acc_en(f_acc_en), .acc_in(f_acc),
        .ready(f_ready), .done(f_done), .result(f_res), .iter_count(f_it));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ext64(input logic [31:0] v, input int w, input bit sgn);
        logic [63:0] mask = (64'd1 << w) - 64'd1;
        logic [63:0] r = {32'd0, v} & mask;
        if (sgn && v[w-1]) r = r | ~mask;
        return r;
    endfunction

    function automatic int exp_iters(input logic [31:0] b, input int w, input int bpc, input bit sgn);
        longint q = longint'(ext64(b, w, sgn)) * 2;
        for (int n = 0; n < 40; n++) begin
            longint t = q >>> (bpc * n);
            if (t == 0 || (sgn && t == -1)) return n;
        end
        return 99;
    endfunction

    task automatic run_small(input logic [7:0] a, input logic [7:0] b, input bit sgn,
                             input bit ae, input logic [15:0] acc, input bit noise);
        logic [63:0] prod;
        logic [15:0] expv, held;
        int n, k, lat;
        prod = ext64({24'd0, a}, SW, sgn) * ext64({24'd0, b}, SW, sgn);
        expv = prod[15:0] + (ae ? acc : 16'd0);
        n    = exp_iters({24'd0, b}, SW, SB, sgn);
        lat  = (n < 1) ? 1 : n;
        @(negedge clk);
        s_a = a; s_b = b; s_sgn = sgn; s_acc_en = ae; s_acc = acc; s_start = 1;
        @(posedge clk);
        @(negedge clk);
        chk(!s_ready, "R6 busy after accept", {63'd0, s_ready}, 64'd0);
        if (noise) begin
            s_start = 1; s_a = ~a; s_b = ~b; s_sgn = ~sgn; s_acc_en = ~ae; s_acc = ~acc;
        end else s_start = 0;
        k = 0;
        do begin
            if (k > 0 || !s_done) begin
                @(posedge clk); k++; @(negedge clk); s_start = 0;
            end
        end while (!s_done && k < 64);
        if (k == 0) k = 0;
        chk(k == lat, "R6 latency", 64'(k), 64'(lat));
        if (noise) chk(s_res == expv, "R8 busy inputs ignored", 64'(s_res), 64'(expv));
        else if (ae) chk(s_res == expv, "R4 accumulate", 64'(s_res), 64'(expv));
        else if (sgn) chk(s_res == expv, "R2 signed product", 64'(s_res), 64'(expv));
        else chk(s_res == expv, "R3 unsigned product", 64'(s_res), 64'(expv));
        chk(int'(s_it) == n, "R5 iteration count", 64'(s_it), 64'(n));
        held = s_res;
        @(posedge clk); @(negedge clk);
        chk(!s_done && s_ready, "R7 single done pulse", {62'd0, s_done, s_ready}, 64'd1);
        chk(s_res == held, "R9 result holds", 64'(s_res), 64'(held));
    endtask

    task automatic run_fast(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                            input bit ae, input logic [63:0] acc);
        logic [63:0] expv;
        int n, k, lat;
        expv = ext64(a, FW, sgn) * ext64(b, FW, sgn) + (ae ? acc : 64'd0);
        n    = exp_iters(b, FW, FB, sgn);
        lat  = (n < 1) ? 1 : n;
        @(negedge clk);
        f_a = a; f_b = b; f_sgn = sgn; f_acc_en = ae; f_acc = acc; f_start = 1;
        @(posedge clk);
        @(negedge clk);
        f_start = 0;
        k = 0;
        while (!f_done && k < 64) begin
            @(posedge clk); k++; @(negedge clk);
        end
        chk(k == lat, "R6 latency fast", 64'(k), 64'(lat));
        chk(f_res == expv, ae ? "R4 accumulate fast" : (sgn ? "R2 signed fast" : "R3 unsigned fast"),
            f_res, expv);
        chk(int'(f_it) == n, "R5 iteration count fast", 64'(f_it), 64'(n));
        chk(n <= (sgn ? 4 : 5), "R5 bound fast", 64'(n), sgn ? 64'd4 : 64'd5);
        @(posedge clk); @(negedge clk);
        chk(!f_done, "R7 single done pulse fast", {63'd0, f_done}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] amul [10] = '{8'h00, 8'h01, 8'hFF, 8'h7F, 8'h80, 8'h55, 8'hAA, 8'h03, 8'hFE, 8'h81};
        int cnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(s_ready && !s_done && s_res == '0, "R1 reset small", 64'(s_res), 64'd0);
        chk(f_ready && !f_done && f_res == '0, "R1 reset fast", f_res, 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(s_ready && !s_done, "R1 idle after reset", {62'd0, s_ready, s_done}, 64'd2);

        for (int ai = 0; ai < 10; ai++) begin
            for (int b = 0; b < 256; b++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    bit ae = ((b + ai) % 5) == 0;
                    bit nz = (cnt % 7) == 3;
                    run_small(amul[ai], 8'(b), sg[0], ae, 16'(b * 977 + ai * 31), nz);
                    cnt++;
                end
            end
        end
        // acc_in ignored when accumulation disabled (R4)
        run_small(8'h12, 8'h34, 1'b1, 1'b0, 16'hBEEF, 1'b0);

        run_fast(32'h0000_0000, 32'h1234_5678, 1'b1, 1'b0, 64'd0);
        run_fast(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 64'd0);
        run_fast(32'h8000_0000, 32'hFFFF_FFFE, 1'b1, 1'b0, 64'd0);
        run_fast(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 64'd0);
        run_fast(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 64'd0);
        run_fast(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 64'd0);
        run_fast(32'h1234_5678, 32'h0000_0005, 1'b0, 1'b0, 64'd0);
        run_fast(32'hDEAD_BEEF, 32'h8765_4321, 1'b0, 1'b0, 64'd0);
        run_fast(32'hDEAD_BEEF, 32'h8765_4321, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF);
        run_fast(32'h0000_00FF, 32'hFFFF_FF80, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        run_fast(32'hCAFE_F00D, 32'h0000_8000, 1'b0, 1'b1, 64'h8000_0000_0000_0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule